// File: doc/BRIEF.md
# Message Cache and Replay Feeder

This block sits between an external ready/valid byte transport and the byte input of a hash engine, for operations that hash the same message twice. On a load pass it forwards each transport byte straight to the hash side. It also keeps the first 4096 message bytes in a local on-chip RAM. On a later replay pass it streams those cached bytes out of RAM without touching the transport. Only after the cached bytes does it pull the remaining tail, offsets 4096 and above, from the transport.

A single-pass use, such as signature checking, runs one load pass and consumes exactly the message length from the transport. A two-pass use runs a load pass and then a replay pass of the same length. The transport then carries N + max(N − 4096, 0) bytes in total. Each pass starts with a `start` pulse, a pass-select bit and the message length. It ends with a one-cycle `done` pulse. `frameErr` stays set until the next start if the transport's last-byte marker disagrees with the length.

Top module: `msg_replay_feeder`

## Requirements
- R1: After reset and whenever idle, `busy`, `done`, `outValid` and `inReady` are low.
- R2: In a load pass (`replayMode`=0) the message bytes 0..N−1 are emitted in order, each transport byte passes through unchanged, `inReady` follows `outReady`, and exactly N transport bytes are consumed.
- R3: A load pass stores bytes at offsets below 4096 in the cache. A following replay pass of the same length emits those same bytes in order.
- R4: During the cached part of a replay pass `inReady` stays low and no transport byte is consumed, even while the transport offers data.
- R5: In a replay pass with N > 4096, the transport bytes for offsets 4096..N−1 follow the cached bytes. The pass consumes exactly N − 4096 transport bytes, so the two passes together consume N + max(N − 4096, 0).
- R6: Cache reads take one cycle. `outValid` rises only once read data is present. While `outReady` is low during replay, `outValid` stays high and `outByte` holds.
- R7: A transport byte marked last (`inLast`=1) at an offset below N−1 ends the pass after that byte, with `done` pulsed and `frameErr` set.
- R8: A transport byte at offset N−1 without `inLast` ends the pass after that byte, with `done` pulsed and `frameErr` set.
- R9: A pass started with length zero emits no byte, consumes no transport byte and pulses `done` in the cycle after `start`.
- R10: `done` is a one-cycle pulse issued when the block returns to idle. `frameErr` is cleared by the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a pass (sampled while idle) |
| replayMode | input | 1 | 0 = load pass, 1 = replay pass |
| msgLen | input | LEN_W | Message length in bytes |
| inByte | input | 8 | Transport byte |
| inValid | input | 1 | Transport byte valid |
| inLast | input | 1 | Transport marks final message byte |
| inReady | output | 1 | Feeder accepts transport byte |
| outByte | output | 8 | Byte to hash engine |
| outValid | output | 1 | Output byte valid |
| outReady | input | 1 | Hash engine accepts byte |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pass completion pulse |
| frameErr | output | 1 | Last-marker mismatch seen in the current or last pass |

## Verification
A stale or skipped cache write, or a wrong read address, shows up as a wrong byte at the first affected replay offset. The scoreboard compares every output byte, so the error is reported at that handshake. A wrong phase change is caught within a cycle, either as `inReady` rising during replay or as an extra, missing or early transport byte. Those are visible in the transport byte count at the `done` pulse. A broken offset counter misplaces the framing check and the tail handover. That surfaces as a wrong `frameErr`, a wrong byte count, or a pass that never finishes.

// File: rtl/msgfeed_pkg.sv
package msgfeed_pkg;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_STREAM = 2'd1, PH_REPLAY = 2'd2} phase_t;

  typedef struct packed {
    logic wrEn;      // write transport byte into cache
    logic rdClear;   // reset replay read pointer
    logic rdRun;     // replay reads allowed
    logic streamSel; // output comes from transport
    logic ramSel;    // output comes from cache
  } feedStrb_t;
endpackage

// File: rtl/msgfeed_ctrl.sv
module msgfeed_ctrl
  import msgfeed_pkg::*;
#(
  parameter int CACHE_BYTES = 4096,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             replayMode,
  input  logic [LEN_W-1:0] msgLen,
  input  logic             inValid,
  input  logic             inLast,
  input  logic             outReady,
  input  logic             ramValid,
  output feedStrb_t        strb,
  output logic [LEN_W-1:0] cnt,
  output logic [LEN_W-1:0] cacheLen,
  output logic             inReady,
  output logic             busy,
  output logic             done,
  output logic             frameErr,
  output phase_t           phase
);
  localparam logic [LEN_W-1:0] CACHE_LEN = LEN_W'(CACHE_BYTES);

  logic [LEN_W-1:0] lenReg;
  logic             modeReg;
  logic             inFire;
  logic             ramFire;
  logic             atLast;

  assign cacheLen = (lenReg < CACHE_LEN) ? lenReg : CACHE_LEN;
  assign atLast   = (cnt == lenReg - LEN_W'(1));
  assign inReady  = (phase == PH_STREAM) && outReady;
  assign inFire   = inReady && inValid;
  assign ramFire  = (phase == PH_REPLAY) && ramValid && outReady;
  assign busy     = (phase != PH_IDLE);

  always_comb begin
    strb.wrEn      = inFire && !modeReg && (cnt < CACHE_LEN);
    strb.rdClear   = (phase == PH_IDLE);
    strb.rdRun     = (phase == PH_REPLAY);
    strb.streamSel = (phase == PH_STREAM);
    strb.ramSel    = (phase == PH_REPLAY);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      lenReg   <= '0;
      modeReg  <= 1'b0;
      cnt      <= '0;
      done     <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start) begin
          lenReg   <= msgLen;
          modeReg  <= replayMode;
          cnt      <= '0;
          frameErr <= 1'b0;
          if (msgLen == '0) done <= 1'b1;
          else phase <= replayMode ? PH_REPLAY : PH_STREAM;
        end
        PH_STREAM: if (inFire) begin
          cnt <= cnt + LEN_W'(1);
          if (inLast != atLast) begin
            frameErr <= 1'b1;
            done     <= 1'b1;
            phase    <= PH_IDLE;
          end else if (atLast) begin
            done  <= 1'b1;
            phase <= PH_IDLE;
          end
        end
        PH_REPLAY: if (ramFire) begin
          cnt <= cnt + LEN_W'(1);
          if (cnt == cacheLen - LEN_W'(1)) begin
            if (lenReg > CACHE_LEN) phase <= PH_STREAM;
            else begin
              done  <= 1'b1;
              phase <= PH_IDLE;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msgfeed_dp.sv
module msgfeed_dp
  import msgfeed_pkg::*;
#(
  parameter int CACHE_BYTES = 4096,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  feedStrb_t        strb,
  input  logic [LEN_W-1:0] cnt,
  input  logic [LEN_W-1:0] cacheLen,
  input  logic [7:0]       inByte,
  input  logic             inValid,
  input  logic             outReady,
  output logic             ramValid,
  output logic [7:0]       outByte,
  output logic             outValid
);
  localparam int ADDR_W = $clog2(CACHE_BYTES);

  logic [7:0]       mem [CACHE_BYTES];
  logic [7:0]       rdData;
  logic [LEN_W-1:0] rdAddr;
  logic             rdEn;

  assign rdEn = strb.rdRun && (!ramValid || outReady) && (rdAddr < cacheLen);

  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[cnt[ADDR_W-1:0]] <= inByte;
    if (rdEn) rdData <= mem[rdAddr[ADDR_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.rdClear) begin
      rdAddr   <= '0;
      ramValid <= 1'b0;
    end else if (strb.rdRun) begin
      if (rdEn) begin
        rdAddr   <= rdAddr + LEN_W'(1);
        ramValid <= 1'b1;
      end else if (outReady) begin
        ramValid <= 1'b0;
      end
    end
  end

  assign outValid = strb.ramSel ? ramValid : (strb.streamSel && inValid);
  assign outByte  = strb.ramSel ? rdData : inByte;
endmodule

// File: rtl/msg_replay_feeder.sv
module msg_replay_feeder
  import msgfeed_pkg::*;
#(
  parameter int CACHE_BYTES = 4096,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             replayMode,
  input  logic [LEN_W-1:0] msgLen,
  input  logic [7:0]       inByte,
  input  logic             inValid,
  input  logic             inLast,
  output logic             inReady,
  output logic [7:0]       outByte,
  output logic             outValid,
  input  logic             outReady,
  output logic             busy,
  output logic             done,
  output logic             frameErr
);
  feedStrb_t        strb;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] cacheLen;
  logic             ramValid;
  phase_t           phase;
  logic [1:0]       phaseNow;

  assign phaseNow = phase;

  msgfeed_ctrl #(.CACHE_BYTES(CACHE_BYTES), .LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .replayMode(replayMode), .msgLen(msgLen),
    .inValid(inValid), .inLast(inLast), .outReady(outReady), .ramValid(ramValid),
    .strb(strb), .cnt(cnt), .cacheLen(cacheLen), .inReady(inReady), .busy(busy),
    .done(done), .frameErr(frameErr), .phase(phase)
  );

  msgfeed_dp #(.CACHE_BYTES(CACHE_BYTES), .LEN_W(LEN_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .cnt(cnt), .cacheLen(cacheLen),
    .inByte(inByte), .inValid(inValid), .outReady(outReady), .ramValid(ramValid),
    .outByte(outByte), .outValid(outValid)
  );
endmodule

// File: rtl/msg_replay_feeder_chk.sv
module msg_replay_feeder_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [LEN_W-1:0] msgLen,
  input logic             busy,
  input logic             done,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [7:0]       outByte,
  input logic [1:0]       phaseNow
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!outValid && !inReady));

  a_r4_no_pull_in_replay: assert property (@(posedge clk) disable iff (!rstN)
    (phaseNow == 2'd2) |-> !inReady);

  a_r6_replay_hold: assert property (@(posedge clk) disable iff (!rstN)
    (phaseNow == 2'd2 && outValid && !outReady) |=> (outValid && $stable(outByte)));

  a_r9_zero_len: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && msgLen == '0) |=> (done && !busy));

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

bind msg_replay_feeder msg_replay_feeder_chk #(.LEN_W(LEN_W)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .msgLen(msgLen), .busy(busy), .done(done),
  .inReady(inReady), .outValid(outValid), .outReady(outReady), .outByte(outByte),
  .phaseNow(phaseNow)
);

// File: tb/tb_msg_replay_feeder.sv
`timescale 1ns/100ps
module tb_msg_replay_feeder;
  localparam int LEN_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic replayMode = 1'b0;
  logic [LEN_W-1:0] msgLen = '0;
  logic [7:0] inByte = '0;
  logic inValid = 1'b0;
  logic inLast = 1'b0;
  logic inReady;
  logic [7:0] outByte;
  logic outValid;
  logic outReady = 1'b0;
  logic busy, done, frameErr;

  always #2.5 clk = ~clk;

  msg_replay_feeder #(.CACHE_BYTES(4096), .LEN_W(LEN_W)) dut (
    .clk(clk), .rstN(rstN), .start(start), .replayMode(replayMode), .msgLen(msgLen),
    .inByte(inByte), .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .outByte(outByte), .outValid(outValid), .outReady(outReady),
    .busy(busy), .done(done), .frameErr(frameErr)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int txFires = 0;
  int readyMode = 0;
  bit fireFlag = 0;
  bit finished = 0;
  logic [7:0] expQ [$];
  string expTag [$];
  logic [7:0] txD [$];
  bit txL [$];

  function automatic logic [7:0] msgByte(int i, int seed);
    return 8'(i * 13 + seed + (i >> 8));
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // transport side observation and output scoreboard monitor
  always @(negedge clk) begin
    fireFlag = inValid && inReady;
    if (fireFlag) txFires++;
    if (outValid && outReady) begin
      if (expQ.size() == 0) check(0, "R2 unexpected output byte", int'(outByte), -1);
      else check(outByte == expQ[0], expTag[0], int'(outByte), int'(expQ[0]));
      if (expQ.size() != 0) begin
        void'(expQ.pop_front());
        void'(expTag.pop_front());
      end
    end
  end

  // transport driver and downstream ready pattern
  always @(posedge clk) begin
    #1;
    cyc++;
    if (fireFlag && txD.size() != 0) begin
      void'(txD.pop_front());
      void'(txL.pop_front());
    end
    if (txD.size() == 0) inValid = 1'b0;
    else if (!(inValid && !fireFlag)) begin
      inValid = (cyc % 5) != 3;
      inByte  = txD[0];
      inLast  = txL[0];
    end
    outReady = (readyMode == 0) ? 1'b1 : ((cyc % 3) != 0);
  end

  task automatic pushTx(int first, int last, int seed, int lastAt);
    for (int i = first; i <= last; i++) begin
      txD.push_back(msgByte(i, seed));
      txL.push_back(i == lastAt);
    end
  endtask

  task automatic pushExp(int first, int last, int seed, string tag);
    for (int i = first; i <= last; i++) begin
      expQ.push_back(msgByte(i, seed));
      expTag.push_back(tag);
    end
  endtask

  task automatic startPass(bit mode, int len);
    @(posedge clk); #1;
    start = 1'b1; replayMode = mode; msgLen = LEN_W'(len);
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic waitDone(string req);
    int k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!done && k < 40000);
    check(done == 1'b1, {req, " done pulse"}, int'(done), 1);
  endtask

  int base;

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done, "R1 busy/done low", int'(busy), 0);
    check(!outValid && !inReady, "R1 outValid/inReady low", int'(outValid), 0);

    // R2/R3 load pass, short message, with downstream stalls
    readyMode = 1;
    base = txFires;
    pushTx(0, 9, 11, 9);
    pushExp(0, 9, 11, "R2 load byte");
    startPass(0, 10);
    waitDone("R2");
    check(txFires - base == 10, "R2 transport count", txFires - base, 10);
    check(expQ.size() == 0, "R2 all bytes emitted", expQ.size(), 0);
    check(frameErr == 1'b0, "R2 no frame error", int'(frameErr), 0);

    // R3/R4 replay of short message while transport offers junk
    base = txFires;
    pushTx(0, 0, 99, 0);
    pushExp(0, 9, 11, "R3 replay byte");
    startPass(1, 10);
    waitDone("R3");
    check(txFires - base == 0, "R4 no transport bytes in replay", txFires - base, 0);
    check(expQ.size() == 0, "R3 all bytes replayed", expQ.size(), 0);
    @(negedge clk);
    txD.delete(); txL.delete();
    repeat (2) @(negedge clk);

    // R5 long message: load then replay with tail fetch
    readyMode = 0;
    base = txFires;
    pushTx(0, 4099, 37, 4099);
    pushExp(0, 4099, 37, "R2 long load byte");
    startPass(0, 4100);
    waitDone("R5 load");
    check(txFires - base == 4100, "R5 load transport count", txFires - base, 4100);

    readyMode = 1;
    base = txFires;
    pushTx(4096, 4099, 37, 4099);
    pushExp(0, 4099, 37, "R5 replay/tail byte");
    startPass(1, 4100);
    waitDone("R5 replay");
    check(txFires - base == 4, "R5 tail transport count", txFires - base, 4);
    check(expQ.size() == 0, "R6 all replay bytes emitted", expQ.size(), 0);
    readyMode = 0;

    // R9 zero length
    base = txFires;
    @(posedge clk); #1;
    start = 1'b1; replayMode = 1'b0; msgLen = '0;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    check(done == 1'b1, "R9 done cycle after start", int'(done), 1);
    check(!outValid && !busy, "R9 no output, idle", int'(outValid), 0);
    @(negedge clk);
    check(done == 1'b0, "R10 done single cycle", int'(done), 0);
    check(txFires == base, "R9 no transport bytes", txFires - base, 0);

    // R7 early last marker
    base = txFires;
    pushTx(0, 4, 5, 4);
    pushExp(0, 4, 5, "R7 byte before early end");
    startPass(0, 8);
    waitDone("R7");
    check(frameErr == 1'b1, "R7 frame error on early last", int'(frameErr), 1);
    check(txFires - base == 5, "R7 transport count", txFires - base, 5);
    @(negedge clk);
    check(!busy, "R7 idle after error", int'(busy), 0);

    // R8 missing last marker
    base = txFires;
    pushTx(0, 5, 8, -1);
    pushExp(0, 5, 8, "R8 byte before late end");
    startPass(0, 6);
    waitDone("R8");
    check(frameErr == 1'b1, "R8 frame error on missing last", int'(frameErr), 1);
    check(txFires - base == 6, "R8 transport count", txFires - base, 6);

    // R10 frame error cleared by next start; single-pass consumes N
    base = txFires;
    pushTx(0, 2, 21, 2);
    pushExp(0, 2, 21, "R2 single pass byte");
    startPass(0, 3);
    check(frameErr == 1'b0, "R10 frame error cleared at start", int'(frameErr), 0);
    waitDone("R10");
    check(frameErr == 1'b0, "R10 clean pass no error", int'(frameErr), 0);
    check(txFires - base == 3, "R2 single pass transport count", txFires - base, 3);
    check(expQ.size() == 0, "R2 queue drained", expQ.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      finished = 1;
      check(0, "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule